// File: doc/BRIEF.md
# Card Configuration and Status Register

This block is one byte-wide register in the attribute space of a removable storage card. The host uses it to look at the card's state and to steer three things. It turns the active-low status-change pin on or off. It declares that only 8-bit I/O cycles are available. It asks for sleep or active power mode. Two of its bits are read-only: one mirrors the change-ready flag kept in the pin-replacement logic, and the other reports the interrupt request after masking by the interrupt-enable control.

Writing a new value to the power bit tells an external power controller that a new state is wanted. From that write the block shows busy, and it keeps showing busy until the controller sends a single-cycle pulse to say the state has been reached. Writes that leave the power bit as it was do not disturb the ready flag.

Top module: `cfg_status_reg`

## Requirements
- R1: After reset the stored fields are 0, so a read returns 0x00 when the change-ready and interrupt inputs are low. Also, `ready`=1, `pwr_down_req`=0, `io8_only`=0 and `stschg_n`=1.
- R2: The register answers only at offset 0x202 (parameter `REG_ADDR`). A write to any other offset changes nothing. A read at any other offset, or with `rd_en` low, returns 0x00.
- R3: Bit 7 reads as the current `chg_ready` input and bit 1 reads as `irq_pending & irq_enable`. Host writes to bits 7 and 1 are ignored.
- R4: Bit 6 is a writable status-change enable. `stschg_n` is 0 exactly when `chg_ready`=1, bit 6=1 and `io_mode`=1. In every other case it is 1.
- R5: Bit 5 is writable, reads back what was written, and drives `io8_only`.
- R6: Bit 2 is writable, reads back what was written, and drives `pwr_down_req`. A value of 1 requests sleep and 0 requests active.
- R7: A write that changes bit 2 makes `ready` 0 from the next cycle on. A write that leaves bit 2 unchanged leaves `ready` as it was.
- R8: While busy, a one-cycle `pwr_ack` pulse makes `ready` 1 on the following cycle. Busy holds until that pulse arrives. A pulse while ready has no effect.
- R9: When a write changing bit 2 lands in the same cycle as `pwr_ack`, the write wins. `ready` stays 0 and waits for a later pulse.
- R10: Bits 4, 3 and 0 always read 0, whatever was written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Attribute-space byte offset |
| wdata | input | 8 | Host write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe |
| io_mode | input | 1 | Card is configured for the I/O interface |
| chg_ready | input | 1 | Change-ready flag from pin-replacement logic |
| irq_pending | input | 1 | Internal interrupt request |
| irq_enable | input | 1 | Interrupt enable from device control |
| pwr_ack | input | 1 | Pulse: requested power state reached |
| rdata | output | 8 | Read data |
| stschg_n | output | 1 | Status-change pin, active low |
| ready | output | 1 | 1 = ready, 0 = busy on power change |
| pwr_down_req | output | 1 | 1 = sleep requested, 0 = active |
| io8_only | output | 1 | Host limited to 8-bit I/O cycles |

## Verification
The power-state acknowledge and a host write that flips the power bit can arrive in the same clock cycle. The bench provokes this by driving `pwr_ack` and such a write together while the block is busy. It then expects `ready` to stay low after that edge, and to rise only after a later lone pulse. It also aims a write that leaves the power bit unchanged at a busy period, to confirm that such a write neither starts nor ends a wait.

// File: rtl/cfg_status_reg.sv
module cfg_status_reg #(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] REG_ADDR = 12'h202
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              io_mode,
  input  logic              chg_ready,
  input  logic              irq_pending,
  input  logic              irq_enable,
  input  logic              pwr_ack,
  output logic [7:0]        rdata,
  output logic              stschg_n,
  output logic              ready,
  output logic              pwr_down_req,
  output logic              io8_only
);

  localparam int B_CHG = 7, B_SIG = 6, B_IO8 = 5, B_PWD = 2, B_IRQ = 1;

  logic sig_en_q, io8_q, pwd_q, busy_q;
  logic hit, wr_hit, pwd_flip, irq_vis;

  assign hit      = (addr == REG_ADDR);
  assign wr_hit   = wr_en && hit;
  assign pwd_flip = wr_hit && (wdata[B_PWD] != pwd_q);
  assign irq_vis  = irq_pending && irq_enable;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sig_en_q <= 1'b0;
      io8_q    <= 1'b0;
      pwd_q    <= 1'b0;
    end else if (wr_hit) begin
      sig_en_q <= wdata[B_SIG];
      io8_q    <= wdata[B_IO8];
      pwd_q    <= wdata[B_PWD];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        busy_q <= 1'b0;
    else if (pwd_flip) busy_q <= 1'b1;
    else if (pwr_ack)  busy_q <= 1'b0;
  end

  always_comb begin
    rdata = 8'h00;
    if (rd_en && hit) begin
      rdata[B_CHG] = chg_ready;
      rdata[B_SIG] = sig_en_q;
      rdata[B_IO8] = io8_q;
      rdata[B_PWD] = pwd_q;
      rdata[B_IRQ] = irq_vis;
    end
  end

  assign stschg_n     = !(chg_ready && sig_en_q && io_mode);
  assign ready        = !busy_q;
  assign pwr_down_req = pwd_q;
  assign io8_only     = io8_q;

  a_r7_busy_on_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == REG_ADDR && wdata[B_PWD] != pwr_down_req) |=> !ready);

  a_r7_no_busy_same: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !(wr_en && addr == REG_ADDR && wdata[B_PWD] != pwr_down_req)) |=> ready);

  a_r8_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && !pwr_ack) |=> !ready);

  a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && pwr_ack && !(wr_en && addr == REG_ADDR && wdata[B_PWD] != pwr_down_req)) |=> ready);

  a_r9_flip_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_ack && wr_en && addr == REG_ADDR && wdata[B_PWD] != pwr_down_req) |=> !ready);

  a_r2_miss_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (addr != REG_ADDR) |=> ($stable(pwr_down_req) && $stable(io8_only)));

  a_r4_sig_off: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == REG_ADDR && !wdata[B_SIG]) |=> stschg_n);

endmodule

// File: tb/cfg_status_reg_tb.sv
module cfg_status_reg_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [11:0] addr = 12'h202;
  logic [7:0] wdata = 8'h00;
  logic wr_en = 1'b0, rd_en = 1'b0, io_mode = 1'b0, chg_ready = 1'b0;
  logic irq_pending = 1'b0, irq_enable = 1'b0, pwr_ack = 1'b0;
  logic [7:0] rdata;
  logic stschg_n, ready, pwr_down_req, io8_only;

  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  cfg_status_reg u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .io_mode(io_mode), .chg_ready(chg_ready),
    .irq_pending(irq_pending), .irq_enable(irq_enable), .pwr_ack(pwr_ack),
    .rdata(rdata), .stschg_n(stschg_n), .ready(ready),
    .pwr_down_req(pwr_down_req), .io8_only(io8_only)
  );

  // {wdata, chg_ready, irq_pending, irq_enable, io_mode, expected read, expected stschg_n}
  localparam logic [20:0] VEC [6] = '{
    {8'hFF, 4'b1111, 8'hE6, 1'b0},
    {8'h00, 4'b1101, 8'h80, 1'b1},
    {8'h40, 4'b0111, 8'h42, 1'b1},
    {8'h40, 4'b1000, 8'hC0, 1'b1},
    {8'h60, 4'b1011, 8'hE0, 1'b0},
    {8'h9B, 4'b0111, 8'h02, 1'b1}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d, input logic ack);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1; pwr_ack = ack;
    @(negedge clk);
    wr_en = 1'b0; pwr_ack = 1'b0; addr = 12'h202;
    #1;
  endtask

  task automatic ack_pulse;
    @(negedge clk);
    pwr_ack = 1'b1;
    @(negedge clk);
    pwr_ack = 1'b0;
    #1;
  endtask

  task automatic rd(input logic [11:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 v = rdata;
    @(negedge clk);
    rd_en = 1'b0; addr = 12'h202;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(12'h202, v);
    chk("R1 read", v, 8'h00);
    chk("R1 outputs", {4'b0, ready, pwr_down_req, io8_only, stschg_n}, 8'h09);

    // R3 R4 R5 R6 R10 vector walk
    foreach (VEC[i]) begin
      wr(12'h202, VEC[i][20:13], 1'b0);
      ack_pulse();
      {chg_ready, irq_pending, irq_enable, io_mode} = VEC[i][12:9];
      rd(12'h202, v);
      chk("R3/R4/R5/R6/R10 read", v, VEC[i][8:1]);
      #1;
      chk("R4 stschg_n", {7'b0, stschg_n}, {7'b0, VEC[i][0]});
      chk("R5 io8_only", {7'b0, io8_only}, {7'b0, VEC[i][6]});
      chk("R6 pwr_down_req", {7'b0, pwr_down_req}, {7'b0, VEC[i][3]});
    end
    {chg_ready, irq_pending, irq_enable, io_mode} = 4'b0000;

    // R2 decode
    wr(12'h203, 8'hFF, 1'b0);
    rd(12'h202, v);
    chk("R2 miss write", v, 8'h00);
    chk("R2 miss no busy", {7'b0, ready}, 8'h01);
    wr(12'h202, 8'h60, 1'b0);
    rd(12'h203, v);
    chk("R2 miss read", v, 8'h00);
    @(negedge clk); #1;
    chk("R2 no rd_en", rdata, 8'h00);

    // R7 busy on change, none on same value
    wr(12'h202, 8'h64, 1'b0);
    chk("R7 busy after flip", {7'b0, ready}, 8'h00);
    repeat (3) @(negedge clk);
    #1 chk("R8 busy holds", {7'b0, ready}, 8'h00);
    wr(12'h202, 8'h24, 1'b0);
    chk("R7 same pwd keeps busy", {7'b0, ready}, 8'h00);
    ack_pulse();
    chk("R8 ack releases", {7'b0, ready}, 8'h01);
    wr(12'h202, 8'h04, 1'b0);
    chk("R7 same pwd no busy", {7'b0, ready}, 8'h01);
    ack_pulse();
    chk("R8 ack while ready", {7'b0, ready}, 8'h01);

    // R9 collision
    wr(12'h202, 8'h00, 1'b0);
    chk("R7 flip to idle", {7'b0, ready}, 8'h00);
    wr(12'h202, 8'h04, 1'b1);
    chk("R9 flip beats ack", {7'b0, ready}, 8'h00);
    chk("R9 pwd updated", {7'b0, pwr_down_req}, 8'h01);
    ack_pulse();
    chk("R9 later ack releases", {7'b0, ready}, 8'h01);

    // R1 reset mid-busy
    wr(12'h202, 8'h60, 1'b0);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd(12'h202, v);
    chk("R1 re-reset read", v, 8'h00);
    chk("R1 re-reset ready", {7'b0, ready}, 8'h01);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule